// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches a running calendar, given as BCD fields for seconds, minute, hour, day of month and day of week, and compares it against four programmable alarm fields. Each alarm field carries its own active-low enable in bit 7, so any subset of the four fields can take part in the match. When every enabled field equals the current time on an update tick whose seconds field reads 00, the block sets a sticky alarm flag. The flag stays set until software clears it. ANDed with an interrupt enable, the flag drives an interrupt request line.

Software reaches the block through a small register port: an address, a write strobe, write data and combinational read data. Control register A (address 0) holds the interrupt enable in bit 1. Control register B (address 1) holds the alarm flag in bit 3. The alarm fields sit at consecutive addresses starting at 2, in the order minute, hour, day of month, day of week. The timekeeping counters and the host serial bus live outside this block, and the match resolves only to the minute.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, the flag and the interrupt request are 0, the interrupt enable is 0, and every alarm field reads 0x80 (field ignored, value 0).
- R2: Register map. Address 0 bit 1 is the interrupt enable. Address 1 bit 3 is the flag. Addresses 2, 3, 4 and 5 hold the minute (7 value bits), hour (6), day of month (6) and day of week (3) alarm fields, each with bit 7 as an active-low enable. Bits outside these fields read 0.
- R3: On a cycle with the tick high, seconds equal to 00 and every enabled field equal to its current-time field, the flag reads 1 from the next cycle. A mismatch on any enabled field leaves the flag at 0.
- R4: A field whose bit 7 is 1 takes no part in the compare, whatever value it stores.
- R5: The flag does not set while the seconds field is not 00, or on a cycle without the tick.
- R6: With all four fields disabled, the flag never sets.
- R7: The flag stays set until software writes 0 to bit 3 at address 1. Writing 1 to that bit leaves the flag unchanged.
- R8: The interrupt request equals flag AND interrupt enable, and it stays asserted for as long as both are 1.
- R9: When a match and a clearing write fall in the same cycle, the flag ends up set.
- R10: The day-of-week field compares all 3 of its bits against the current weekday.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timeTick | input | 1 | One-cycle strobe marking a calendar update |
| curSec | input | 7 | Current seconds, BCD |
| curMin | input | 7 | Current minute, BCD |
| curHour | input | 6 | Current hour, BCD |
| curDate | input | 6 | Current day of month, BCD |
| curWday | input | 3 | Current day of week |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| alarmFlag | output | 1 | Sticky alarm flag |
| alarmIrq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit register port, a 3-bit address, field widths of 7/6/6/3 bits, control registers at addresses 0 and 1, and the alarm fields from address 2. These widths reach the full minute field and the narrow weekday field, so value bits above each field's width are shown to drop on readback. The same defaults put the flag and enable bits where software expects them, which lets the bench test a same-cycle clear against a match and test a write of 1 to the flag bit.

// File: rtl/calAlarmPkg.sv
package calAlarmPkg;
  localparam int NUM_FIELDS = 4;

  // Strobes from the control decoder to the datapath.
  typedef struct packed {
    logic                  wrIntEn;
    logic                  wrFlag;
    logic [NUM_FIELDS-1:0] wrField;
    logic                  rdCtrlA;
    logic                  rdCtrlB;
    logic [NUM_FIELDS-1:0] rdField;
    logic                  evalTick;
  } strobes_t;
endpackage

// File: rtl/cal_alarm_ctrl.sv
module cal_alarm_ctrl
  import calAlarmPkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int CTRL_A_ADDR = 0,
  parameter int CTRL_B_ADDR = 1,
  parameter int ALARM_BASE  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              timeTick,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output strobes_t          strb
);
  localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(CTRL_A_ADDR);
  localparam logic [ADDR_W-1:0] B_ADDR = ADDR_W'(CTRL_B_ADDR);

  logic hitA, hitB;
  logic [NUM_FIELDS-1:0] hitField;

  assign hitA = (regAddr == A_ADDR);
  assign hitB = (regAddr == B_ADDR);

  // One decoder per alarm field, consecutive addresses from the base.
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] F_ADDR = ADDR_W'(ALARM_BASE + i);
    assign hitField[i] = (regAddr == F_ADDR);
  end

  always_comb begin
    strb          = '0;
    strb.wrIntEn  = regWrEn & hitA;
    strb.wrFlag   = regWrEn & hitB;
    strb.wrField  = {NUM_FIELDS{regWrEn}} & hitField;
    strb.rdCtrlA  = hitA;
    strb.rdCtrlB  = hitB;
    strb.rdField  = hitField;
    strb.evalTick = timeTick;
  end

  // R2: at most one register written per cycle.
  assert_one_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrIntEn, strb.wrFlag, strb.wrField}));

  // R2: at most one register selected for read.
  assert_one_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdCtrlA, strb.rdCtrlB, strb.rdField}));
endmodule

// File: rtl/cal_alarm_dp.sv
module cal_alarm_dp
  import calAlarmPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SEC_W    = 7,
  parameter int MIN_W    = 7,
  parameter int HOUR_W   = 6,
  parameter int DATE_W   = 6,
  parameter int WDAY_W   = 3,
  parameter int IE_BIT   = 1,
  parameter int FLAG_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEC_W-1:0]  curSec,
  input  logic [MIN_W-1:0]  curMin,
  input  logic [HOUR_W-1:0] curHour,
  input  logic [DATE_W-1:0] curDate,
  input  logic [WDAY_W-1:0] curWday,
  output logic [DATA_W-1:0] rdData,
  output logic              alarmFlag,
  output logic              irq
);
  localparam int FW     = DATA_W - 1;  // value bits below the enable
  localparam int IGN_B  = DATA_W - 1;  // active-low enable position

  logic [FW-1:0] curFld [NUM_FIELDS];
  assign curFld[0] = FW'(curMin);
  assign curFld[1] = FW'(curHour);
  assign curFld[2] = FW'(curDate);
  assign curFld[3] = FW'(curWday);

  logic [NUM_FIELDS-1:0]         ignVec;
  logic [NUM_FIELDS-1:0]         fieldHit;
  logic [NUM_FIELDS-1:0][FW-1:0] valVec;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    localparam int W = (i == 0) ? MIN_W : (i == 1) ? HOUR_W :
                       (i == 2) ? DATE_W : WDAY_W;
    localparam logic [FW-1:0] MASK = {FW{1'b1}} >> (FW - W);
    logic [FW-1:0] val;
    logic          ign;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        val <= '0;
        ign <= 1'b1;
      end else if (strb.wrField[i]) begin
        val <= wrData[FW-1:0] & MASK;
        ign <= wrData[IGN_B];
      end
    end

    assign valVec[i]   = val;
    assign ignVec[i]   = ign;
    assign fieldHit[i] = ign | (val == curFld[i]);
  end

  logic secZero, alarmHit, clearReq, intEn;
  assign secZero  = (curSec == '0);
  assign alarmHit = strb.evalTick & secZero & ~(&ignVec) & (&fieldHit);
  assign clearReq = strb.wrFlag & ~wrData[FLAG_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmFlag <= 1'b0;
    end else if (alarmHit) begin
      alarmFlag <= 1'b1;          // a new match outranks a clear
    end else if (clearReq) begin
      alarmFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             intEn <= 1'b0;
    else if (strb.wrIntEn) intEn <= wrData[IE_BIT];
  end

  assign irq = alarmFlag & intEn;

  always_comb begin
    rdData = '0;
    if (strb.rdCtrlA) rdData[IE_BIT]   = intEn;
    if (strb.rdCtrlB) rdData[FLAG_BIT] = alarmFlag;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (strb.rdField[i]) rdData = {ignVec[i], valVec[i]};
    end
  end

  assert_set_needs_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!alarmFlag && !(strb.evalTick && curSec == '0)) |=> !alarmFlag);

  assert_all_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!alarmFlag && (&ignVec)) |=> !alarmFlag);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !clearReq) |=> alarmFlag);

  assert_match_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evalTick && secZero && ~(&ignVec) && (&fieldHit)) |=> alarmFlag);

  assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clearReq && !strb.wrIntEn) |=> irq);
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import calAlarmPkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SEC_W       = 7,
  parameter int MIN_W       = 7,
  parameter int HOUR_W      = 6,
  parameter int DATE_W      = 6,
  parameter int WDAY_W      = 3,
  parameter int CTRL_A_ADDR = 0,
  parameter int CTRL_B_ADDR = 1,
  parameter int ALARM_BASE  = 2,
  parameter int IE_BIT      = 1,
  parameter int FLAG_BIT    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              timeTick,
  input  logic [SEC_W-1:0]  curSec,
  input  logic [MIN_W-1:0]  curMin,
  input  logic [HOUR_W-1:0] curHour,
  input  logic [DATE_W-1:0] curDate,
  input  logic [WDAY_W-1:0] curWday,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              alarmFlag,
  output logic              alarmIrq
);
  strobes_t strb;

  cal_alarm_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_A_ADDR(CTRL_A_ADDR),
    .CTRL_B_ADDR(CTRL_B_ADDR), .ALARM_BASE(ALARM_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .timeTick(timeTick),
    .regAddr(regAddr), .regWrEn(regWrEn), .strb(strb)
  );

  cal_alarm_dp #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W),
    .DATE_W(DATE_W), .WDAY_W(WDAY_W), .IE_BIT(IE_BIT), .FLAG_BIT(FLAG_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .curSec(curSec), .curMin(curMin), .curHour(curHour),
    .curDate(curDate), .curWday(curWday),
    .rdData(regRdData), .alarmFlag(alarmFlag), .irq(alarmIrq)
  );
endmodule

// File: tb/sim_cal_alarm_match.sv
`timescale 1ns/1ps
module sim_cal_alarm_match;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       timeTick = 1'b0;
  logic [6:0] curSec = '0;
  logic [6:0] curMin = '0;
  logic [5:0] curHour = '0;
  logic [5:0] curDate = '0;
  logic [2:0] curWday = '0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       alarmFlag, alarmIrq;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  cal_alarm_match u0 (
    .clk(clk), .rstN(rstN), .timeTick(timeTick), .curSec(curSec),
    .curMin(curMin), .curHour(curHour), .curDate(curDate), .curWday(curWday),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .alarmFlag(alarmFlag), .alarmIrq(alarmIrq)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // Pulse one tick with the given calendar; flag is sampled at the next negedge.
  task automatic doTick(input logic [6:0] s, input logic [6:0] m,
                        input logic [5:0] h, input logic [5:0] dt,
                        input logic [2:0] wd);
    @(negedge clk);
    curSec = s; curMin = m; curHour = h; curDate = dt; curWday = wd;
    timeTick = 1'b1;
    @(negedge clk);
    timeTick = 1'b0;
  endtask

  task automatic setAlarm(input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] dt, input logic [7:0] wd);
    writeReg(3'd2, m); writeReg(3'd3, h); writeReg(3'd4, dt); writeReg(3'd5, wd);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1", "flag", {7'b0, alarmFlag}, 8'h00);
    chk("R1", "irq", {7'b0, alarmIrq}, 8'h00);
    readReg(3'd0, d); chk("R1", "ctrlA", d, 8'h00);
    readReg(3'd1, d); chk("R1", "ctrlB", d, 8'h00);
    for (int a = 2; a < 6; a++) begin
      readReg(3'(a), d); chk("R1", "alarm field", d, 8'h80);
    end
  endtask

  task automatic t_regmap;
    logic [7:0] d;
    writeReg(3'd0, 8'hFF); readReg(3'd0, d); chk("R2", "ctrlA readback", d, 8'h02);
    writeReg(3'd0, 8'h00); readReg(3'd0, d); chk("R2", "ctrlA cleared", d, 8'h00);
    setAlarm(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    readReg(3'd2, d); chk("R2", "minute width", d, 8'hFF);
    readReg(3'd3, d); chk("R2", "hour width", d, 8'hBF);
    readReg(3'd4, d); chk("R2", "date width", d, 8'hBF);
    readReg(3'd5, d); chk("R10", "weekday width", d, 8'h87);
    readReg(3'd6, d); chk("R2", "unused address", d, 8'h00);
    setAlarm(8'h80, 8'h80, 8'h80, 8'h80);
  endtask

  task automatic t_fullMatch;
    setAlarm(8'h30, 8'h12, 8'h15, 8'h03);
    doTick(7'h00, 7'h30, 6'h11, 6'h15, 3'd3);
    chk("R3", "hour mismatch", {7'b0, alarmFlag}, 8'h00);
    doTick(7'h00, 7'h30, 6'h12, 6'h15, 3'd2);
    chk("R10", "weekday mismatch", {7'b0, alarmFlag}, 8'h00);
    doTick(7'h00, 7'h30, 6'h12, 6'h15, 3'd3);
    chk("R3", "full match", {7'b0, alarmFlag}, 8'h01);
    writeReg(3'd1, 8'h00);
  endtask

  task automatic t_seconds;
    doTick(7'h01, 7'h30, 6'h12, 6'h15, 3'd3);
    chk("R5", "seconds nonzero", {7'b0, alarmFlag}, 8'h00);
    @(negedge clk);
    curSec = 7'h00; curMin = 7'h30; curHour = 6'h12; curDate = 6'h15; curWday = 3'd3;
    @(negedge clk);
    @(negedge clk);
    chk("R5", "no tick", {7'b0, alarmFlag}, 8'h00);
  endtask

  task automatic t_subset;
    setAlarm(8'h45, 8'h91, 8'h82, 8'h86);
    doTick(7'h00, 7'h45, 6'h07, 6'h28, 3'd1);
    chk("R4", "minute only", {7'b0, alarmFlag}, 8'h01);
    writeReg(3'd1, 8'h00);
    setAlarm(8'h80, 8'h80, 8'h80, 8'h05);
    doTick(7'h00, 7'h12, 6'h03, 6'h09, 3'd4);
    chk("R10", "weekday only, differs", {7'b0, alarmFlag}, 8'h00);
    doTick(7'h00, 7'h12, 6'h03, 6'h09, 3'd5);
    chk("R10", "weekday only, equal", {7'b0, alarmFlag}, 8'h01);
    writeReg(3'd1, 8'h00);
  endtask

  task automatic t_allOff;
    setAlarm(8'h80, 8'h80, 8'h80, 8'h80);
    doTick(7'h00, 7'h00, 6'h00, 6'h00, 3'd0);
    chk("R6", "all disabled, zero time", {7'b0, alarmFlag}, 8'h00);
    setAlarm(8'hA5, 8'h92, 8'h97, 8'h86);
    doTick(7'h00, 7'h25, 6'h12, 6'h17, 3'd6);
    chk("R6", "all disabled, equal values", {7'b0, alarmFlag}, 8'h00);
  endtask

  task automatic t_sticky;
    logic [7:0] d;
    setAlarm(8'h10, 8'h80, 8'h80, 8'h80);
    doTick(7'h00, 7'h10, 6'h00, 6'h01, 3'd0);
    chk("R7", "set", {7'b0, alarmFlag}, 8'h01);
    doTick(7'h00, 7'h11, 6'h00, 6'h01, 3'd0);
    chk("R7", "holds after mismatch", {7'b0, alarmFlag}, 8'h01);
    writeReg(3'd1, 8'h08);
    readReg(3'd1, d); chk("R7", "write 1 no effect", d, 8'h08);
    writeReg(3'd1, 8'hF7);
    chk("R7", "write 0 clears", {7'b0, alarmFlag}, 8'h00);
  endtask

  task automatic t_irq;
    doTick(7'h00, 7'h10, 6'h00, 6'h01, 3'd0);
    chk("R8", "flag without enable", {7'b0, alarmIrq}, 8'h00);
    writeReg(3'd0, 8'h02);
    chk("R8", "enable raises irq", {7'b0, alarmIrq}, 8'h01);
    repeat (5) @(negedge clk);
    chk("R8", "irq held", {7'b0, alarmIrq}, 8'h01);
    writeReg(3'd1, 8'h00);
    chk("R8", "clear drops irq", {7'b0, alarmIrq}, 8'h00);
    doTick(7'h00, 7'h10, 6'h05, 6'h02, 3'd1);
    chk("R8", "match with enable", {7'b0, alarmIrq}, 8'h01);
    writeReg(3'd0, 8'h00);
    chk("R8", "disable drops irq", {7'b0, alarmIrq}, 8'h00);
    writeReg(3'd1, 8'h00);
  endtask

  task automatic t_race;
    @(negedge clk);
    curSec = 7'h00; curMin = 7'h10; curHour = 6'h00; curDate = 6'h01; curWday = 3'd0;
    timeTick = 1'b1;
    regAddr = 3'd1; regWrData = 8'h00; regWrEn = 1'b1;
    @(negedge clk);
    timeTick = 1'b0; regWrEn = 1'b0;
    chk("R9", "match beats clear", {7'b0, alarmFlag}, 8'h01);
    writeReg(3'd1, 8'h00);
    chk("R9", "later clear", {7'b0, alarmFlag}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_regmap;
    t_fullMatch;
    t_seconds;
    t_subset;
    t_allOff;
    t_sticky;
    t_irq;
    t_race;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule